// File: doc/BRIEF.md
# Privilege Mode and Stack Bank Controller

This block holds the two privilege bits of a 16-bit status word: supervisor level and master/interrupt mode. From them it picks which of three banked stack pointers answers to address register 7, and it drives a 3-bit function code that marks every bus reference as user or supervisor, program or data. It does no instruction decode and no stack traffic. The sequencer hands it one-cycle command strobes and takes back registered results.

The sequencer can issue three kinds of command:

- **Exception entry**, with a flag that says whether it is an interrupt.
- **Status-word rewrite**: move, AND, OR or XOR with an immediate operand.
- **Return from exception**, carrying the restored status word and a frame-kind flag.

On exception entry the block registers the old status word as the value to push. On every permitted rewrite or return it emits a one-cycle refill strobe for the fetch unit. Rewrites and returns attempted at user level are rejected with a one-cycle violation strobe.

All command inputs are plain strobes, and the block accepts one command in every cycle. There is no back-pressure. When more than one command arrives in the same cycle, the lower-priority ones are dropped, and the sequencer must not expect them to take effect.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the status word is 0x2000 (bit 13 = supervisor = 1, bit 12 = master = 0). The refill, violation, push-valid and full-restore strobes are all 0.
- R2: An exception entry causes the following effects in the next cycle. `push_valid` is 1 for one cycle. `push_sr` equals the status word from before the entry. Bit 13 of the status word is set.
- R3: On entry of an interrupt exception, bit 12 is cleared. On entry of a non-interrupt exception, bit 12 keeps its value.
- R4: At supervisor level, a status-word rewrite takes effect in the next cycle. The `sr_op` encodings are: 0 replaces the word with the operand; 1 ANDs the operand in; 2 ORs it in; 3 XORs it in.
- R5: At user level, a rewrite or a return leaves the status word unchanged. It raises `priv_viol` for exactly one cycle and gives no refill.
- R6: A permitted rewrite or return gives `refill` = 1 in the next cycle only.
- R7: A permitted return replaces the status word with `rte_sr`. `full_restore` is 1 for one cycle when `rte_fault` = 1 and stays 0 when `rte_fault` = 0.
- R8: `sp_sel` selects the stack pointer:
  - 0 (user) whenever bit 13 is 0;
  - 1 (interrupt) when bit 13 = 1 and bit 12 = 0;
  - 2 (master) when bit 13 = 1 and bit 12 = 1.
- R9: `fc` takes one of four values, chosen by the supervisor bit and the `prog_ref` input:
  - 3'b001: user data (`prog_ref` = 0);
  - 3'b010: user program (`prog_ref` = 1);
  - 3'b101: supervisor data (`prog_ref` = 0);
  - 3'b110: supervisor program (`prog_ref` = 1).
- R10: In a cycle with several commands, exception entry wins over return, and return wins over rewrite. Only the winner has any effect.
- R11: Bit 13 can go from 0 to 1 only through an exception entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception entry strobe |
| exc_is_irq | input | 1 | The exception being entered is an interrupt |
| sr_op_valid | input | 1 | Status-word rewrite strobe |
| sr_op | input | 2 | Rewrite kind: 0 move, 1 and, 2 or, 3 xor |
| sr_operand | input | 16 | Rewrite operand |
| rte_req | input | 1 | Return-from-exception strobe |
| rte_sr | input | 16 | Status word restored by the return |
| rte_fault | input | 1 | Frame is a bus/address fault frame |
| prog_ref | input | 1 | Current bus reference is a program fetch |
| sr_q | output | 16 | Current status word |
| push_sr | output | 16 | Status word to push on exception entry |
| push_valid | output | 1 | `push_sr` is fresh this cycle |
| sp_sel | output | 2 | Stack pointer bank: 0 user, 1 interrupt, 2 master |
| fc | output | 3 | Function code for the current reference |
| priv_viol | output | 1 | Privilege violation strobe |
| refill | output | 1 | Pipeline refill strobe |
| full_restore | output | 1 | Return needs a full-state restore |

## Verification
The assertions take for granted that every command strobe lasts a single cycle and that the command inputs are clean (0 or 1) once reset is released. They make no assumption about how commands combine, because the priority is checked directly.

The stimulus drives each command for exactly one clock, away from the sampling edge, and then returns all strobes to 0. It deliberately issues commands at the same time only in the priority scenario. The expected value of the status word after each command follows from the requirement encodings alone.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [1:0] {
    SROP_MOVE = 2'd0,
    SROP_AND  = 2'd1,
    SROP_OR   = 2'd2,
    SROP_XOR  = 2'd3
  } srop_e;

  typedef enum logic [1:0] {
    SP_USER   = 2'd0,
    SP_INTR   = 2'd1,
    SP_MASTER = 2'd2
  } spsel_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_RTE  = 2'd2,
    EV_SROP = 2'd3
  } event_e;

  localparam logic [2:0] FC_USER_DATA = 3'b001;
  localparam logic [2:0] FC_USER_PROG = 3'b010;
  localparam logic [2:0] FC_SUP_DATA  = 3'b101;
  localparam logic [2:0] FC_SUP_PROG  = 3'b110;
endpackage

// File: rtl/priv_arb.sv
module priv_arb
  import priv_pkg::*;
(
  input  logic   exc_req,
  input  logic   rte_req,
  input  logic   sr_op_valid,
  output event_e ev
);
  // Fixed priority: exception, then return, then rewrite.
  always_comb begin
    if (exc_req)          ev = EV_EXC;
    else if (rte_req)     ev = EV_RTE;
    else if (sr_op_valid) ev = EV_SROP;
    else                  ev = EV_NONE;
  end
endmodule

// File: rtl/priv_sr.sv
module priv_sr
  import priv_pkg::*;
#(
  parameter int          SR_W     = 16,
  parameter int          S_BIT    = 13,
  parameter int          M_BIT    = 12,
  parameter logic [SR_W-1:0] RESET_SR = 16'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  event_e          ev,
  input  logic            exc_is_irq,
  input  srop_e           sr_op,
  input  logic [SR_W-1:0] sr_operand,
  input  logic [SR_W-1:0] rte_sr,
  input  logic            rte_fault,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] push_sr,
  output logic            push_valid,
  output logic            priv_viol,
  output logic            refill,
  output logic            full_restore
);
  logic            sup;
  logic [SR_W-1:0] sr_d;
  logic [SR_W-1:0] op_res;
  logic            viol_d, refill_d, full_d, push_d;

  assign sup = sr_q[S_BIT];

  always_comb begin
    unique case (sr_op)
      SROP_MOVE: op_res = sr_operand;
      SROP_AND:  op_res = sr_q & sr_operand;
      SROP_OR:   op_res = sr_q | sr_operand;
      default:   op_res = sr_q ^ sr_operand;
    endcase
  end

  always_comb begin
    sr_d     = sr_q;
    viol_d   = 1'b0;
    refill_d = 1'b0;
    full_d   = 1'b0;
    push_d   = 1'b0;
    unique case (ev)
      EV_EXC: begin
        sr_d[S_BIT] = 1'b1;
        if (exc_is_irq) sr_d[M_BIT] = 1'b0;
        push_d = 1'b1;
      end
      EV_RTE: begin
        if (sup) begin
          sr_d     = rte_sr;
          refill_d = 1'b1;
          full_d   = rte_fault;
        end else begin
          viol_d = 1'b1;
        end
      end
      EV_SROP: begin
        if (sup) begin
          sr_d     = op_res;
          refill_d = 1'b1;
        end else begin
          viol_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q         <= RESET_SR;
      push_sr      <= '0;
      push_valid   <= 1'b0;
      priv_viol    <= 1'b0;
      refill       <= 1'b0;
      full_restore <= 1'b0;
    end else begin
      sr_q         <= sr_d;
      push_valid   <= push_d;
      priv_viol    <= viol_d;
      refill       <= refill_d;
      full_restore <= full_d;
      if (push_d) push_sr <= sr_q;
    end
  end

  // R2: the pushed word is the pre-entry word, and supervisor is set
  assert_push_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_EXC |=> push_valid && push_sr == $past(sr_q) && sr_q[S_BIT]);

  // R3: interrupt entry clears master mode
  assert_irq_clear_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_EXC && exc_is_irq |=> !sr_q[M_BIT]);

  // R3: other exceptions keep master mode
  assert_exc_keep_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_EXC && !exc_is_irq |=> sr_q[M_BIT] == $past(sr_q[M_BIT]));

  // R5: a user-level attempt is rejected without touching the word
  assert_user_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RTE || ev == EV_SROP) && !sup |=> priv_viol && !refill && $stable(sr_q));

  // R6: a permitted rewrite or return yields a refill strobe
  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RTE || ev == EV_SROP) && sup |=> refill);

  // R6: the refill strobe lasts one cycle unless a new command re-arms it
  assert_refill_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill && ev == EV_NONE |=> !refill);

  // R11: supervisor rises only through exception entry
  assert_s_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q[S_BIT]) |-> $past(ev == EV_EXC));
endmodule

// File: rtl/priv_view.sv
module priv_view
  import priv_pkg::*;
(
  input  logic       sup,
  input  logic       master,
  input  logic       prog_ref,
  output logic [1:0] sp_sel,
  output logic [2:0] fc
);
  always_comb begin
    if (!sup)        sp_sel = SP_USER;
    else if (master) sp_sel = SP_MASTER;
    else             sp_sel = SP_INTR;
  end

  always_comb begin
    unique case ({sup, prog_ref})
      2'b00:   fc = FC_USER_DATA;
      2'b01:   fc = FC_USER_PROG;
      2'b10:   fc = FC_SUP_DATA;
      default: fc = FC_SUP_PROG;
    endcase
  end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_pkg::*;
#(
  parameter int SR_W  = 16,
  parameter int S_BIT = 13,
  parameter int M_BIT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            exc_is_irq,
  input  logic            sr_op_valid,
  input  logic [1:0]      sr_op,
  input  logic [SR_W-1:0] sr_operand,
  input  logic            rte_req,
  input  logic [SR_W-1:0] rte_sr,
  input  logic            rte_fault,
  input  logic            prog_ref,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] push_sr,
  output logic            push_valid,
  output logic [1:0]      sp_sel,
  output logic [2:0]      fc,
  output logic            priv_viol,
  output logic            refill,
  output logic            full_restore
);
  localparam logic [SR_W-1:0] RESET_SR = SR_W'(1) << S_BIT;

  event_e ev;

  priv_arb u_arb (
    .exc_req     (exc_req),
    .rte_req     (rte_req),
    .sr_op_valid (sr_op_valid),
    .ev          (ev)
  );

  priv_sr #(
    .SR_W     (SR_W),
    .S_BIT    (S_BIT),
    .M_BIT    (M_BIT),
    .RESET_SR (RESET_SR)
  ) u_sr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev           (ev),
    .exc_is_irq   (exc_is_irq),
    .sr_op        (srop_e'(sr_op)),
    .sr_operand   (sr_operand),
    .rte_sr       (rte_sr),
    .rte_fault    (rte_fault),
    .sr_q         (sr_q),
    .push_sr      (push_sr),
    .push_valid   (push_valid),
    .priv_viol    (priv_viol),
    .refill       (refill),
    .full_restore (full_restore)
  );

  priv_view u_view (
    .sup      (sr_q[S_BIT]),
    .master   (sr_q[M_BIT]),
    .prog_ref (prog_ref),
    .sp_sel   (sp_sel),
    .fc       (fc)
  );

  // R8: user level always banks the user stack pointer
  assert_user_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_q[S_BIT] |-> sp_sel == 2'd0);

  // R8: supervisor level never banks the user stack pointer
  assert_sup_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[S_BIT] |-> sp_sel != 2'd0);

  // R9: the function code's top bit follows the supervisor bit
  assert_fc_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fc[2] == sr_q[S_BIT]);

  // R10: exception entry suppresses a competing return or rewrite
  assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !refill && !priv_viol && !full_restore);

  // R1: the strobes come out of reset low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !refill && !priv_viol && !push_valid && !full_restore);
endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 0, exc_is_irq = 0, sr_op_valid = 0, rte_req = 0;
  logic        rte_fault = 0, prog_ref = 0;
  logic [1:0]  sr_op = 0;
  logic [15:0] sr_operand = 0, rte_sr = 0;
  logic [15:0] sr_q, push_sr;
  logic        push_valid, priv_viol, refill, full_restore;
  logic [1:0]  sp_sel;
  logic [2:0]  fc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_is_irq(exc_is_irq),
    .sr_op_valid(sr_op_valid), .sr_op(sr_op), .sr_operand(sr_operand),
    .rte_req(rte_req), .rte_sr(rte_sr), .rte_fault(rte_fault),
    .prog_ref(prog_ref), .sr_q(sr_q), .push_sr(push_sr),
    .push_valid(push_valid), .sp_sel(sp_sel), .fc(fc),
    .priv_viol(priv_viol), .refill(refill), .full_restore(full_restore)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of commands after a falling edge, then sample at the
  // following falling edge, by which time the registered results are out.
  task automatic step(input logic exc, input logic irq, input logic opv,
                      input logic [1:0] op, input logic [15:0] opnd,
                      input logic rte, input logic [15:0] rsr, input logic flt);
    @(negedge clk);
    exc_req = exc; exc_is_irq = irq; sr_op_valid = opv; sr_op = op;
    sr_operand = opnd; rte_req = rte; rte_sr = rsr; rte_fault = flt;
    @(negedge clk);
    exc_req = 0; exc_is_irq = 0; sr_op_valid = 0; rte_req = 0; rte_fault = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 2'd0, 16'h0, 0, 16'h0, 0);
  endtask

  task automatic do_move(input logic [15:0] v);
    step(0, 0, 1, 2'd0, v, 0, 16'h0, 0);
  endtask

  task automatic t_reset();
    chk("R1 sr", sr_q, 16'h2000);
    chk("R1 refill", refill, 0);
    chk("R1 viol", priv_viol, 0);
    chk("R1 push_valid", push_valid, 0);
    chk("R1 full_restore", full_restore, 0);
    chk("R8 sp reset interrupt", sp_sel, 2'd1);
    prog_ref = 0; #1;
    chk("R9 fc sup data", fc, 3'b101);
    prog_ref = 1; #1;
    chk("R9 fc sup prog", fc, 3'b110);
    prog_ref = 0;
  endtask

  task automatic t_srops();
    do_move(16'h3700);
    chk("R4 move", sr_q, 16'h3700);
    chk("R6 refill move", refill, 1);
    chk("R8 sp master", sp_sel, 2'd2);
    step(0, 0, 1, 2'd1, 16'hFF0F, 0, 16'h0, 0);
    chk("R4 and", sr_q, 16'h3700 & 16'hFF0F);
    step(0, 0, 1, 2'd2, 16'h0005, 0, 16'h0, 0);
    chk("R4 or", sr_q, 16'h3705);
    step(0, 0, 1, 2'd3, 16'h1000, 0, 16'h0, 0);
    chk("R4 xor", sr_q, 16'h2705);
    chk("R8 sp interrupt", sp_sel, 2'd1);
    idle();
    chk("R6 refill one cycle", refill, 0);
  endtask

  task automatic t_exc();
    do_move(16'h3000);
    step(1, 0, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    chk("R2 push_valid", push_valid, 1);
    chk("R2 push_sr", push_sr, 16'h3000);
    chk("R3 nonirq keeps M", sr_q, 16'h3000);
    step(1, 1, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    chk("R2 push_sr irq", push_sr, 16'h3000);
    chk("R3 irq clears M", sr_q, 16'h2000);
    idle();
    chk("R2 push_valid one cycle", push_valid, 0);
    do_move(16'h0000);
    chk("R8 sp user", sp_sel, 2'd0);
    prog_ref = 0; #1;
    chk("R9 fc user data", fc, 3'b001);
    prog_ref = 1; #1;
    chk("R9 fc user prog", fc, 3'b010);
    prog_ref = 0;
    step(1, 1, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    chk("R2 user entry sets S", sr_q, 16'h2000);
    chk("R2 user entry push", push_sr, 16'h0000);
    do_move(16'h1000);
    chk("R8 sp user with M", sp_sel, 2'd0);
    step(1, 0, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    chk("R3 nonirq from user keeps M", sr_q, 16'h3000);
  endtask

  task automatic t_user_viol();
    do_move(16'h0000);
    do_move(16'h2000);
    chk("R5 move rejected", sr_q, 16'h0000);
    chk("R11 S stays clear", sr_q[13], 0);
    chk("R5 viol", priv_viol, 1);
    chk("R5 no refill", refill, 0);
    step(0, 0, 1, 2'd2, 16'h2000, 0, 16'h0, 0);
    chk("R5 or rejected", sr_q, 16'h0000);
    step(0, 0, 0, 2'd0, 16'h0, 1, 16'h2000, 0);
    chk("R5 rte rejected", sr_q, 16'h0000);
    chk("R5 rte viol", priv_viol, 1);
    idle();
    chk("R5 viol one cycle", priv_viol, 0);
  endtask

  task automatic t_rte();
    step(1, 0, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    step(0, 0, 0, 2'd0, 16'h0, 1, 16'h0015, 0);
    chk("R7 restore", sr_q, 16'h0015);
    chk("R7 no full", full_restore, 0);
    chk("R6 refill rte", refill, 1);
    step(1, 0, 0, 2'd0, 16'h0, 0, 16'h0, 0);
    step(0, 0, 0, 2'd0, 16'h0, 1, 16'h3000, 1);
    chk("R7 fault restore", sr_q, 16'h3000);
    chk("R7 full", full_restore, 1);
    idle();
    chk("R7 full one cycle", full_restore, 0);
  endtask

  task automatic t_priority();
    do_move(16'h2000);
    step(1, 0, 1, 2'd0, 16'h0000, 1, 16'h0700, 0);
    chk("R10 exc wins sr", sr_q, 16'h2000);
    chk("R10 exc push", push_valid, 1);
    chk("R10 exc no refill", refill, 0);
    step(0, 0, 1, 2'd0, 16'h0000, 1, 16'h2700, 0);
    chk("R10 rte wins sr", sr_q, 16'h2700);
    chk("R10 rte refill", refill, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_srops();
    t_exc();
    t_user_viol();
    t_rte();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule